// File: doc/BRIEF.md
# Serial Clock Configuration Register Bank

This block sits beside a clock generator and holds its configuration. A host writes to it over a two-wire serial bus (clock plus open-drain data). After the slave address, the block ignores a command byte and a byte-count byte. The bytes that follow land in four configuration registers, in order:

- a control byte carrying the frequency code, spread type, frequency source and output mode;
- three output-enable bytes.

Register changes reach the decoded outputs only when the stop condition arrives, so the generator never sees a half-written set.

The frequency code can come from a register field or from a hardware select pin. The control byte picks which. A strap pin is sampled once after reset to fix whether the fixed-frequency output runs at 24 MHz or 48 MHz. All serial lines are synchronised into the system clock and sampled there. The block acknowledges by asserting `sda_oe_o`, which pulls the shared data line low.

Top module: `clk_cfg_regbank`

## Requirements
- R1: Only an address byte whose upper seven bits equal `SLAVE_ADDR` (default 7'h69) and whose last bit is 0 (write) is acknowledged. Any other address gets no acknowledge, and nothing from that transfer reaches any output.
- R2: After the address byte and every later byte of a matched transfer, the block holds the data line low for the whole ninth clock pulse.
- R3: The first two bytes after the address are discarded. The third byte is the control byte, and the next three are the enable bytes, in order.
- R4: When control bit 3 is 0, `freq_code_o` is {`hw_sel_i`, 2'b11}: 3'b111 is 100 MHz and 3'b011 is 66.6 MHz. When control bit 3 is 1, `freq_code_o` is control bits 6:4.
- R5: `spread_down_o` equals control bit 7 (0 = center spread, 1 = down spread). `mode_o` equals control bits 1:0: 00 normal, 01 test, 10 spread on, 11 all outputs tristate.
- R6: Enable byte 1 bits 3:0 drive `cpu_en_o`. Enable byte 2 bits 7:0 drive `pci_en_o`, where bit 7 is the free-running bus clock. Enable byte 3 bits 5:4 drive `apic_en_o` and bits 2:0 drive `ref_en_o`. All other bits of the enable bytes have no effect.
- R7: After reset the control byte is 0 and every enable output is 1.
- R8: `strap_i` is captured on the first clock after reset: 1 gives `fixed_24m_o` = 1 (24 MHz), 0 gives 48 MHz. Later changes of `strap_i` have no effect until the next reset.
- R9: Written bytes change the outputs only after the stop condition. Before the stop, the outputs keep their previous values.
- R10: Data bytes after the fourth are acknowledged and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial bus clock |
| sda_i | input | 1 | Serial bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| hw_sel_i | input | 1 | Hardware frequency select, 1 = 100 MHz |
| strap_i | input | 1 | Strap sampled once after reset |
| freq_code_o | output | 3 | Effective frequency code |
| spread_down_o | output | 1 | Spread type, 1 = down spread |
| mode_o | output | 2 | Output mode |
| cpu_en_o | output | 4 | Processor clock enables |
| pci_en_o | output | 8 | Bus clock enables, bit 7 free-running |
| apic_en_o | output | 2 | Interrupt-controller clock enables |
| ref_en_o | output | 3 | Reference clock enables |
| fixed_24m_o | output | 1 | 1 = fixed output at 24 MHz, 0 = 48 MHz |

## Verification
The hardest case to reach from the ports is the window between the last data bit and the stop condition. Here the shadow copy already holds new values but the outputs must not move yet. The bench writes a control byte, and while the bus is still held inside the transfer it samples the mode and frequency outputs against the old values. Only then does it issue the stop. The strap is covered by changing the pin after reset and again across a second reset. Each vector's command and count bytes carry values that would visibly alter the outputs if they were stored by mistake.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
package clkcfg_pkg;
  localparam int NUM_BYTES = 4;
  localparam int IDX_W     = 3;
  localparam int CTRL_IDX  = 0;
  localparam int CPU_IDX   = 1;
  localparam int PCI_IDX   = 2;
  localparam int PER_IDX   = 3;
  localparam int PREAMBLE  = 3;  // address, command, count

  typedef enum logic [1:0] {MODE_NORMAL, MODE_TEST, MODE_SPREAD, MODE_HIZ} out_mode_e;
  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_ACK, RX_SKIP} rx_state_e;

  function automatic logic [7:0] rst_val(int i);
    case (i)
      CPU_IDX: return 8'h0F;
      PCI_IDX: return 8'hFF;
      PER_IDX: return 8'h37;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wr_mask(int i);
    case (i)
      CPU_IDX: return 8'h0F;
      PCI_IDX: return 8'hFF;
      PER_IDX: return 8'h37;
      default: return 8'hFB;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_serial_rx.sv
`timescale 1ns/1ps
module clkcfg_serial_rx
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic             wr_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             start_o,
  output logic             stop_o
);
  localparam int CNT_W = 4;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;
  rx_state_e state_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [IDX_W-1:0] byte_num;
  logic [7:0] shreg;
  logic matched_q;
  logic [7:0] byte_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_sync[SYNC_STAGES-1];
  assign sda_s     = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign byte_now  = {shreg[6:0], sda_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      bit_cnt   <= '0;
      byte_num  <= '0;
      shreg     <= '0;
      matched_q <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_o      <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      start_o   <= 1'b0;
      stop_o    <= 1'b0;
    end else begin
      wr_o    <= 1'b0;
      start_o <= start_det;
      stop_o  <= stop_det & matched_q;
      if (start_det) begin
        state_q   <= RX_BITS;
        bit_cnt   <= '0;
        byte_num  <= '0;
        matched_q <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else if (stop_det) begin
        state_q   <= RX_IDLE;
        matched_q <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else begin
        unique case (state_q)
          RX_BITS: begin
            if (scl_rise && bit_cnt < CNT_W'(8)) begin
              shreg   <= byte_now;
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == CNT_W'(7)) begin
                if (byte_num == '0) begin
                  if (shreg[6:0] == SLAVE_ADDR && !sda_s) matched_q <= 1'b1;
                  else state_q <= RX_SKIP;
                end else if (byte_num >= IDX_W'(PREAMBLE)) begin
                  wr_o      <= 1'b1;
                  wr_idx_o  <= byte_num - IDX_W'(PREAMBLE);
                  wr_data_o <= byte_now;
                end
              end
            end else if (scl_fall && bit_cnt == CNT_W'(8)) begin
              state_q  <= RX_ACK;
              sda_oe_o <= 1'b1;
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              state_q  <= RX_BITS;
              bit_cnt  <= '0;
              if (byte_num != '1) byte_num <= byte_num + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_wr_matched_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> matched_q);
  p_ack_matched_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> matched_q);
endmodule

// File: rtl/clkcfg_regs.sv
`timescale 1ns/1ps
module clkcfg_regs
  import clkcfg_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          wr_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [7:0]                    data_i,
  input  logic                          commit_i,
  output logic [NUM_BYTES-1:0][7:0]     cfg_o
);
  logic [NUM_BYTES-1:0][7:0] shadow_q;
  logic pending_q;
  logic do_commit;

  assign do_commit = commit_i & pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= 1'b0;
    else if (start_i || do_commit) pending_q <= 1'b0;
    else if (wr_i && idx_i < IDX_W'(NUM_BYTES)) pending_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[g]    <= rst_val(g);
        shadow_q[g] <= rst_val(g);
      end else begin
        if (start_i) shadow_q[g] <= cfg_o[g];
        else if (wr_i && idx_i == IDX_W'(g)) shadow_q[g] <= data_i & wr_mask(g);
        if (do_commit) cfg_o[g] <= shadow_q[g];
      end
    end
  end

  p_atomic_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !do_commit |=> $stable(cfg_o));
  p_cpu_rsvd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[CPU_IDX][7:4] == 4'h0);
endmodule

// File: rtl/clkcfg_decode.sv
`timescale 1ns/1ps
module clkcfg_decode
  import clkcfg_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_BYTES-1:0][7:0] cfg_i,
  input  logic                      hw_sel_i,
  input  logic                      strap_i,
  output logic [2:0]                freq_code_o,
  output logic                      spread_down_o,
  output out_mode_e                 mode_o,
  output logic [3:0]                cpu_en_o,
  output logic [7:0]                pci_en_o,
  output logic [1:0]                apic_en_o,
  output logic [2:0]                ref_en_o,
  output logic                      fixed_24m_o
);
  logic strap_done_q;
  logic [7:0] ctrl;

  assign ctrl = cfg_i[CTRL_IDX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_done_q <= 1'b0;
      fixed_24m_o  <= 1'b0;
    end else if (!strap_done_q) begin
      strap_done_q <= 1'b1;
      fixed_24m_o  <= strap_i;
    end
  end

  always_comb begin
    freq_code_o   = ctrl[3] ? ctrl[6:4] : {hw_sel_i, 2'b11};
    spread_down_o = ctrl[7];
    mode_o        = out_mode_e'(ctrl[1:0]);
    cpu_en_o      = cfg_i[CPU_IDX][3:0];
    pci_en_o      = cfg_i[PCI_IDX];
    apic_en_o     = cfg_i[PER_IDX][5:4];
    ref_en_o      = cfg_i[PER_IDX][2:0];
  end

  p_strap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_done_q |=> $stable(fixed_24m_o));
endmodule

// File: rtl/clk_cfg_regbank.sv
`timescale 1ns/1ps
module clk_cfg_regbank
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       hw_sel_i,
  input  logic       strap_i,
  output logic [2:0] freq_code_o,
  output logic       spread_down_o,
  output logic [1:0] mode_o,
  output logic [3:0] cpu_en_o,
  output logic [7:0] pci_en_o,
  output logic [1:0] apic_en_o,
  output logic [2:0] ref_en_o,
  output logic       fixed_24m_o
);
  logic             wr, start, stop;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;
  logic [NUM_BYTES-1:0][7:0] cfg;
  out_mode_e        mode;

  clkcfg_serial_rx #(.SLAVE_ADDR(SLAVE_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i, .rst_ni, .scl_i, .sda_i, .sda_oe_o,
    .wr_o(wr), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .start_o(start), .stop_o(stop)
  );

  clkcfg_regs u_regs (
    .clk_i, .rst_ni, .start_i(start), .wr_i(wr), .idx_i(wr_idx),
    .data_i(wr_data), .commit_i(stop), .cfg_o(cfg)
  );

  clkcfg_decode u_dec (
    .clk_i, .rst_ni, .cfg_i(cfg), .hw_sel_i, .strap_i,
    .freq_code_o, .spread_down_o, .mode_o(mode), .cpu_en_o, .pci_en_o,
    .apic_en_o, .ref_en_o, .fixed_24m_o
  );

  assign mode_o = mode;
endmodule

// File: tb/clk_cfg_regbank_test.sv
`timescale 1ns/1ps
module clk_cfg_regbank_test;
  localparam int Q = 10;
  localparam logic [7:0] ADDR_W = 8'hD2;
  localparam logic [7:0] ADDR_BAD = 8'hD4;
  localparam int NVEC = 7;
  // {ctrl, hw_sel, exp_code, exp_mode, exp_down}
  localparam logic [14:0] VEC [NVEC] = '{
    {8'h00, 1'b1, 3'b111, 2'b00, 1'b0},
    {8'h00, 1'b0, 3'b011, 2'b00, 1'b0},
    {8'h08, 1'b1, 3'b000, 2'b00, 1'b0},
    {8'h58, 1'b0, 3'b101, 2'b00, 1'b0},
    {8'hA9, 1'b1, 3'b010, 2'b01, 1'b1},
    {8'hF2, 1'b0, 3'b011, 2'b10, 1'b1},
    {8'h3B, 1'b0, 3'b011, 2'b11, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, hw_sel = 1'b1, strap = 1'b1;
  logic sda_oe, sda_line;
  logic [2:0] freq_code; logic spread_down; logic [1:0] mode;
  logic [3:0] cpu_en; logic [7:0] pci_en; logic [1:0] apic_en; logic [2:0] ref_en;
  logic fixed_24m;
  int checks = 0, fails = 0;
  logic ack;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  clk_cfg_regbank uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .hw_sel_i(hw_sel), .strap_i(strap), .freq_code_o(freq_code),
    .spread_down_o(spread_down), .mode_o(mode), .cpu_en_o(cpu_en), .pci_en_o(pci_en),
    .apic_en_o(apic_en), .ref_en_o(ref_en), .fixed_24m_o(fixed_24m)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic got_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    got_ack = ~sda_line;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic write_ctrl(input logic [7:0] c, output logic all_ack);
    logic a;
    all_ack = 1'b1;
    bus_start();
    send_byte(ADDR_W, a); all_ack &= a;
    send_byte(8'hFF, a); all_ack &= a;   // command, would set mode 11 if stored
    send_byte(8'hFF, a); all_ack &= a;   // count
    send_byte(c, a); all_ack &= a;
    bus_stop();
    wq(10);
  endtask

  task automatic do_reset(input logic s);
    strap = s; rst_n = 1'b0; wq(5); rst_n = 1'b1; wq(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic a;
    do_reset(1'b1);
    // R7 defaults, R8 strap high
    check("R7 mode", mode, 2'b00);
    check("R7 down", spread_down, 1'b0);
    check("R7 code hw", freq_code, 3'b111);
    check("R7 cpu", cpu_en, 4'hF);
    check("R7 pci", pci_en, 8'hFF);
    check("R7 apic", apic_en, 2'h3);
    check("R7 ref", ref_en, 3'h7);
    check("R8 strap 24", fixed_24m, 1'b1);

    // R3 R4 R5: control vectors
    for (int v = 0; v < NVEC; v++) begin
      hw_sel = VEC[v][6];
      write_ctrl(VEC[v][14:7], a);
      check("R2 ack", a, 1'b1);
      check("R4 code", freq_code, VEC[v][5:3]);
      check("R5 mode", mode, VEC[v][2:1]);
      check("R5 down", spread_down, VEC[v][0]);
    end

    // R6 R10: all four bytes plus an extra one
    hw_sel = 1'b1;
    bus_start();
    send_byte(ADDR_W, a); send_byte(8'h00, a); send_byte(8'h04, a);
    send_byte(8'h00, a); send_byte(8'hA5, a); send_byte(8'h5A, a); send_byte(8'hC8, a);
    send_byte(8'hFF, a);
    check("R10 extra acked", a, 1'b1);
    bus_stop(); wq(10);
    check("R6 cpu", cpu_en, 4'h5);
    check("R6 pci", pci_en, 8'h5A);
    check("R6 apic", apic_en, 2'h0);
    check("R6 ref", ref_en, 3'h0);
    check("R10 ctrl kept", mode, 2'b00);

    // R6: reserved bits of peripheral byte
    bus_start();
    send_byte(ADDR_W, a); send_byte(8'h00, a); send_byte(8'h04, a);
    send_byte(8'h00, a); send_byte(8'hF0, a); send_byte(8'h81, a); send_byte(8'hC9, a);
    bus_stop(); wq(10);
    check("R6 cpu rsvd", cpu_en, 4'h0);
    check("R6 pci bits", pci_en, 8'h81);
    check("R6 per rsvd apic", apic_en, 2'h0);
    check("R6 per rsvd ref", ref_en, 3'h1);

    // R9: no change before stop
    bus_start();
    send_byte(ADDR_W, a); send_byte(8'h00, a); send_byte(8'h01, a);
    send_byte(8'h4B, a);
    wq(10);
    check("R9 mode before stop", mode, 2'b00);
    check("R9 code before stop", freq_code, 3'b111);
    bus_stop(); wq(10);
    check("R9 mode after stop", mode, 2'b11);
    check("R9 code after stop", freq_code, 3'b100);

    // R1: wrong address
    bus_start();
    send_byte(ADDR_BAD, a);
    check("R1 no ack", a, 1'b0);
    send_byte(8'h00, a); send_byte(8'h01, a); send_byte(8'h00, a);
    bus_stop(); wq(10);
    check("R1 mode kept", mode, 2'b11);
    check("R1 code kept", freq_code, 3'b100);
    // R1: read bit set
    bus_start();
    send_byte(ADDR_W | 8'h01, a);
    check("R1 read no ack", a, 1'b0);
    bus_stop(); wq(10);

    // R8: later strap change ignored, then reset with strap low
    strap = 1'b0; wq(20);
    check("R8 strap held", fixed_24m, 1'b1);
    do_reset(1'b0);
    check("R8 strap 48", fixed_24m, 1'b0);
    check("R7 mode after reset", mode, 2'b00);
    check("R7 pci after reset", pci_en, 8'hFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule